// File: doc/BRIEF.md
# Power Profile Flatness Monitor

The monitor watches a stream of per-cycle power figures during a scan test session. Each figure is a count of flip-flop transitions. A session opens with a start strobe. It closes with an end strobe. While the session is open, every sample marked valid is counted and added to a running sum and a running sum of squares. Downstream logic can derive the mean and the variance from these three totals, since the variance is (1/N)·Σ(P−mean)², which equals ΣP²/N − (ΣP/N)². The block does not divide.

Two flatness measures are also kept. The first is the number of consecutive sample pairs whose relative change exceeds a programmable threshold. The test is done without a divider, by comparing a scaled difference against a product. The second is a peak check. A pulse marks any sample above a programmable limit. A sticky flag records that a violation happened, together with the position of the first violating sample.

The totals and the jump count are captured when the session ends and are held until the next session produces new results.

Top module: `pwr_flat_mon`

## Requirements
- R1: After reset, all result outputs are zero, and `res_vld`, `peak_now` and `peak_hit` are low.
- R2: An end strobe applied while a session is open captures the sample count, ΣP and ΣP² on that clock edge, including a valid sample given in the same cycle. `res_vld` is high from the next cycle until the next start strobe.
- R3: A sample counts only when `smp_vld` is high, a session is open, and `sess_start` is low. Samples given outside a session, or in the start cycle, leave all results unchanged. Idle cycles inside a session do not break the pairing of consecutive accepted samples.
- R4: For consecutive accepted samples p then c, the jump count rises when |p−c|·2^8 > gamma·p. `thr_gamma` is an unsigned 12-bit value with 8 fractional bits, so 13 stands for about 0.05. Equality does not count.
- R5: When p is 0, a nonzero c counts as a jump, and c equal to 0 does not.
- R6: `peak_now` is high for the cycle after an accepted sample strictly greater than `peak_lim`. A sample equal to the limit does not raise it.
- R7: `peak_hit` is sticky. `peak_idx` holds the zero-based position, among the session's accepted samples, of the first sample above the limit. Later violations do not change it. Only a start strobe clears both.
- R8: While `res_vld` stays high, `res_cnt`, `res_sum`, `res_sumsq` and `res_jumps` do not change.
- R9: With defaults, sessions of up to 65535 samples of value up to 255 produce exact totals, with no wrap. For example, 255,255 gives ΣP = 510 and ΣP² = 130050.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sess_start | input | 1 | Opens a new session; clears running totals and peak state |
| sess_end | input | 1 | Closes the open session and captures results |
| smp_vld | input | 1 | Sample strobe |
| smp_val | input | VAL_W (8) | Per-cycle transition count |
| thr_gamma | input | GAM_W (12) | Relative jump threshold, GAM_FRAC (8) fractional bits |
| peak_lim | input | VAL_W (8) | Peak limit |
| res_vld | output | 1 | Captured results are valid |
| res_cnt | output | CNT_W (16) | Number of accepted samples |
| res_sum | output | VAL_W+CNT_W (24) | Sum of samples |
| res_sumsq | output | 2·VAL_W+CNT_W (32) | Sum of squared samples |
| res_jumps | output | CNT_W (16) | Number of threshold-exceeding jumps |
| peak_now | output | 1 | Pulse for a sample above the limit |
| peak_hit | output | 1 | Sticky peak-violation flag |
| peak_idx | output | CNT_W (16) | Position of the first violating sample |

## Verification
The assertions assume that reset is held low over the first clock edge. They also assume that no session runs longer than the counter range, because the jump count never reaching the sample count depends on it. The stimulus always asserts reset before any strobe and keeps sessions to a few samples, far below 65535. It also opens every session with a start strobe before sending any samples.

// File: rtl/pfm_pkg.sv
// Package: shared helpers for the power profile flatness monitor.
// Assumes unsigned operands; widths are set by the caller's parameters.
package pfm_pkg;

    // Decide whether the step prev -> cur is a relative jump above gamma.
    // The test |prev-cur|*2^frac > gamma*prev is done in a common width
    // wide enough for both sides, so no product is truncated.
    function automatic logic rel_jump(
        input logic [31:0] prev,
        input logic [31:0] cur,
        input logic [31:0] gamma,
        input int unsigned frac
    );
        logic [63:0] diff;
        logic [63:0] lhs;
        logic [63:0] rhs;
        diff = (prev > cur) ? 64'(prev - cur) : 64'(cur - prev);
        lhs  = diff << frac;
        rhs  = 64'(gamma) * 64'(prev);
        return lhs > rhs;
    endfunction

endpackage

// File: rtl/pfm_accum.sv
// Running count, sum and sum of squares for one session.
// Assumes the session never holds more than 2^CNT_W-1 samples.
// The *_nxt outputs include the sample taken this cycle.
module pfm_accum #(
    parameter int VAL_W = 8,
    parameter int CNT_W = 16,
    localparam int SUM_W = VAL_W + CNT_W,
    localparam int SQ_W  = 2 * VAL_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [VAL_W-1:0] val,
    output logic [CNT_W-1:0] cnt_cur,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic [SUM_W-1:0] sum_nxt,
    output logic [SQ_W-1:0]  sq_nxt
);
    logic [SUM_W-1:0] sum_q;
    logic [SQ_W-1:0]  sq_q;

    // Next totals with this cycle's accepted sample folded in.
    always_comb begin
        cnt_nxt = cnt_cur;
        sum_nxt = sum_q;
        sq_nxt  = sq_q;
        if (take) begin
            cnt_nxt = cnt_cur + CNT_W'(1);
            sum_nxt = sum_q + SUM_W'(val);
            sq_nxt  = sq_q + SQ_W'(val) * SQ_W'(val);
        end
    end

    // Register the totals; a session start zeroes them.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_cur <= '0;
            sum_q   <= '0;
            sq_q    <= '0;
        end else begin
            cnt_cur <= cnt_nxt;
            sum_q   <= sum_nxt;
            sq_q    <= sq_nxt;
        end
    end
endmodule

// File: rtl/pfm_jump.sv
// Counts relative jumps between consecutive accepted samples.
// Assumes gamma is unsigned fixed point with GAM_FRAC fractional bits.
// A zero previous sample makes any nonzero step a jump.
module pfm_jump #(
    parameter int VAL_W    = 8,
    parameter int CNT_W    = 16,
    parameter int GAM_W    = 12,
    parameter int GAM_FRAC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [VAL_W-1:0] val,
    input  logic [GAM_W-1:0] gamma,
    output logic [CNT_W-1:0] jump_nxt
);
    import pfm_pkg::*;

    logic [VAL_W-1:0] prev_q;
    logic             have_prev_q;
    logic [CNT_W-1:0] jump_q;
    logic             hit;

    // Compare the new sample against the previous accepted one.
    always_comb begin
        hit      = take && have_prev_q &&
                   rel_jump(32'(prev_q), 32'(val), 32'(gamma), GAM_FRAC);
        jump_nxt = jump_q + (hit ? CNT_W'(1) : CNT_W'(0));
    end

    // Keep the previous sample and the running jump count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            jump_q      <= '0;
        end else begin
            jump_q <= jump_nxt;
            if (take) begin
                prev_q      <= val;
                have_prev_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfm_peak.sv
// Peak-limit watcher: one-cycle pulse per violation, sticky flag, and the
// position of the first violating sample. Cleared only by session start.
module pfm_peak #(
    parameter int VAL_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [VAL_W-1:0] val,
    input  logic [VAL_W-1:0] lim,
    input  logic [CNT_W-1:0] pos,
    output logic             peak_now,
    output logic             peak_hit,
    output logic [CNT_W-1:0] peak_idx
);
    logic over;

    // A violation is an accepted sample strictly above the limit.
    always_comb over = take && (val > lim);

    // Pulse, sticky flag and first-position capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            peak_now <= 1'b0;
            peak_hit <= 1'b0;
            peak_idx <= '0;
        end else begin
            peak_now <= over;
            if (over && !peak_hit) begin
                peak_hit <= 1'b1;
                peak_idx <= pos;
            end
        end
    end
endmodule

// File: rtl/pwr_flat_mon.sv
// Top of the power profile flatness monitor. It tracks the session window,
// gates samples into the accumulators, and captures results at session end.
// Assumes the start strobe wins over an end strobe in the same cycle.
module pwr_flat_mon #(
    parameter int VAL_W    = 8,
    parameter int CNT_W    = 16,
    parameter int GAM_W    = 12,
    parameter int GAM_FRAC = 8,
    localparam int SUM_W   = VAL_W + CNT_W,
    localparam int SQ_W    = 2 * VAL_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sess_start,
    input  logic             sess_end,
    input  logic             smp_vld,
    input  logic [VAL_W-1:0] smp_val,
    input  logic [GAM_W-1:0] thr_gamma,
    input  logic [VAL_W-1:0] peak_lim,
    output logic             res_vld,
    output logic [CNT_W-1:0] res_cnt,
    output logic [SUM_W-1:0] res_sum,
    output logic [SQ_W-1:0]  res_sumsq,
    output logic [CNT_W-1:0] res_jumps,
    output logic             peak_now,
    output logic             peak_hit,
    output logic [CNT_W-1:0] peak_idx
);
    logic             open_q;
    logic             take;
    logic             close;
    logic [CNT_W-1:0] cnt_cur;
    logic [CNT_W-1:0] cnt_nxt;
    logic [SUM_W-1:0] sum_nxt;
    logic [SQ_W-1:0]  sq_nxt;
    logic [CNT_W-1:0] jump_nxt;

    // Sample acceptance and session close qualification.
    always_comb begin
        take  = smp_vld && open_q && !sess_start;
        close = sess_end && open_q && !sess_start;
    end

    pfm_accum #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(sess_start), .take(take),
        .val(smp_val), .cnt_cur(cnt_cur), .cnt_nxt(cnt_nxt),
        .sum_nxt(sum_nxt), .sq_nxt(sq_nxt)
    );

    pfm_jump #(.VAL_W(VAL_W), .CNT_W(CNT_W), .GAM_W(GAM_W),
               .GAM_FRAC(GAM_FRAC)) u_jump (
        .clk(clk), .rst_n(rst_n), .clr(sess_start), .take(take),
        .val(smp_val), .gamma(thr_gamma), .jump_nxt(jump_nxt)
    );

    pfm_peak #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_peak (
        .clk(clk), .rst_n(rst_n), .clr(sess_start), .take(take),
        .val(smp_val), .lim(peak_lim), .pos(cnt_cur),
        .peak_now(peak_now), .peak_hit(peak_hit), .peak_idx(peak_idx)
    );

    // Session window and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q    <= 1'b0;
            res_vld   <= 1'b0;
            res_cnt   <= '0;
            res_sum   <= '0;
            res_sumsq <= '0;
            res_jumps <= '0;
        end else if (sess_start) begin
            open_q  <= 1'b1;
            res_vld <= 1'b0;
        end else if (close) begin
            open_q    <= 1'b0;
            res_vld   <= 1'b1;
            res_cnt   <= cnt_nxt;
            res_sum   <= sum_nxt;
            res_sumsq <= sq_nxt;
            res_jumps <= jump_nxt;
        end
    end
endmodule

// File: rtl/pwr_flat_mon_chk.sv
// Checker for pwr_flat_mon, attached by bind. Watches ports only.
module pwr_flat_mon_chk #(
    parameter int CNT_W = 16,
    parameter int SUM_W = 24,
    parameter int SQ_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sess_start,
    input logic             sess_end,
    input logic             res_vld,
    input logic [CNT_W-1:0] res_cnt,
    input logic [SUM_W-1:0] res_sum,
    input logic [SQ_W-1:0]  res_sumsq,
    input logic [CNT_W-1:0] res_jumps,
    input logic             peak_now,
    input logic             peak_hit,
    input logic [CNT_W-1:0] peak_idx
);
    // R2: results become valid only right after an end strobe.
    a_r2_vld_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_vld) |-> $past(sess_end));

    // R8: captured results hold while valid stays high.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(res_vld)) |->
        ($stable(res_cnt) && $stable(res_sum) && $stable(res_sumsq) && $stable(res_jumps)));

    // R7: sticky flag and first index survive unless a start strobe came.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(peak_hit) && !$past(sess_start)) |-> (peak_hit && $stable(peak_idx)));

    // R7: a start strobe clears peak state and result validity.
    a_r7_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sess_start) |-> (!peak_hit && !peak_now && !res_vld));

    // R6: every pulse is reflected in the sticky flag.
    a_r6_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        peak_now |-> peak_hit);

    // R4: with N samples there are at most N-1 pairs, so jumps stay below count.
    a_r4_jumps_below_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> ((res_cnt == '0) || (res_jumps < res_cnt)));

    // R9: sum of squares never falls below the sum for integer samples.
    a_r9_sq_ge_sum: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (SQ_W'(res_sum) <= res_sumsq));
endmodule

bind pwr_flat_mon pwr_flat_mon_chk #(
    .CNT_W(CNT_W), .SUM_W(SUM_W), .SQ_W(SQ_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .sess_end(sess_end),
    .res_vld(res_vld), .res_cnt(res_cnt), .res_sum(res_sum),
    .res_sumsq(res_sumsq), .res_jumps(res_jumps), .peak_now(peak_now),
    .peak_hit(peak_hit), .peak_idx(peak_idx)
);

// File: tb/test_pwr_flat_mon.sv
// Directed bench for pwr_flat_mon: one task per scenario.
module test_pwr_flat_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sess_start = 1'b0;
    logic        sess_end = 1'b0;
    logic        smp_vld = 1'b0;
    logic [7:0]  smp_val = '0;
    logic [11:0] thr_gamma = 12'd13;
    logic [7:0]  peak_lim = 8'd255;
    logic        res_vld;
    logic [15:0] res_cnt;
    logic [23:0] res_sum;
    logic [31:0] res_sumsq;
    logic [15:0] res_jumps;
    logic        peak_now;
    logic        peak_hit;
    logic [15:0] peak_idx;

    int checks = 0;
    int errors = 0;
    int pk_seen = 0;
    int seq_q[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    pwr_flat_mon i_pwr_flat_mon (
        .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .sess_end(sess_end),
        .smp_vld(smp_vld), .smp_val(smp_val), .thr_gamma(thr_gamma),
        .peak_lim(peak_lim), .res_vld(res_vld), .res_cnt(res_cnt),
        .res_sum(res_sum), .res_sumsq(res_sumsq), .res_jumps(res_jumps),
        .peak_now(peak_now), .peak_hit(peak_hit), .peak_idx(peak_idx)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Play seq_q as one session; -1 is an idle cycle. End rides on the last sample.
    task automatic play();
        pk_seen = 0;
        @(negedge clk) sess_start = 1'b1;
        @(negedge clk) sess_start = 1'b0;
        foreach (seq_q[i]) begin
            smp_vld  = (seq_q[i] >= 0);
            smp_val  = (seq_q[i] >= 0) ? 8'(seq_q[i]) : 8'd0;
            sess_end = (i == seq_q.size() - 1);
            @(negedge clk);
            if (peak_now) pk_seen++;
        end
        smp_vld  = 1'b0;
        sess_end = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 res_vld", res_vld, 0);
        check("R1 res_cnt", res_cnt, 0);
        check("R1 res_sumsq", res_sumsq, 0);
        check("R1 peak_hit", peak_hit, 0);
        check("R1 peak_now", peak_now, 0);
    endtask

    task automatic t_basic();
        thr_gamma = 12'd13; peak_lim = 8'd4;
        seq_q = '{4, 4, 4, 4, 5, 4, 2};
        play();
        check("R2 res_vld", res_vld, 1);
        check("R2 count", res_cnt, 7);
        check("R2 sum", res_sum, 27);
        check("R2 sumsq", res_sumsq, 109);
        check("R4 jumps", res_jumps, 3);
        check("R6 pulses", pk_seen, 1);
        check("R7 peak_hit", peak_hit, 1);
        check("R7 peak_idx", peak_idx, 4);
    endtask

    task automatic t_zero();
        thr_gamma = 12'd13; peak_lim = 8'd255;
        seq_q = '{0, 0, 3, 0};
        play();
        check("R5 jumps from zero", res_jumps, 2);
        check("R5 sum", res_sum, 3);
        check("R6 no pulse", pk_seen, 0);
        check("R7 cleared by start", peak_hit, 0);
    endtask

    task automatic t_boundary();
        thr_gamma = 12'd128; peak_lim = 8'd15;
        seq_q = '{10, 15, 10, 16};
        play();
        check("R4 equality not counted", res_jumps, 1);
        check("R6 equal to limit", pk_seen, 1);
        check("R7 first index", peak_idx, 3);
    endtask

    task automatic t_gaps();
        thr_gamma = 12'd13; peak_lim = 8'd1;
        seq_q = '{2, -1, -1, 2, 3, -1, 9};
        play();
        check("R3 count skips idle", res_cnt, 4);
        check("R3 pairing across idle", res_jumps, 2);
        check("R7 later violations keep index", peak_idx, 0);
        check("R6 pulses", pk_seen, 4);
    endtask

    task automatic t_outside();
        seq_q = '{7, 8};
        thr_gamma = 12'd13; peak_lim = 8'd255;
        play();
        // samples and an end strobe while closed: results and state unchanged
        @(negedge clk) begin smp_vld = 1'b1; smp_val = 8'd200; end
        @(negedge clk) begin smp_val = 8'd1; sess_end = 1'b1; peak_lim = 8'd0; end
        @(negedge clk) begin smp_vld = 1'b0; sess_end = 1'b0; end
        check("R3 closed count", res_cnt, 2);
        check("R8 held sum", res_sum, 15);
        check("R3 closed no peak", peak_hit, 0);
        check("R2 still valid", res_vld, 1);
        // a sample in the start cycle is ignored
        @(negedge clk) begin sess_start = 1'b1; smp_vld = 1'b1; smp_val = 8'd50; end
        @(negedge clk) begin sess_start = 1'b0; smp_val = 8'd3; sess_end = 1'b1; end
        check("R2 valid drops on start", res_vld, 0);
        @(negedge clk) begin smp_vld = 1'b0; sess_end = 1'b0; end
        check("R3 start-cycle sample ignored", res_sum, 3);
        check("R3 start-cycle count", res_cnt, 1);
        check("R7 start-cycle no peak idx", peak_idx, 0);
    endtask

    task automatic t_max();
        thr_gamma = 12'd13; peak_lim = 8'd255;
        seq_q = '{255, 255};
        play();
        check("R9 sum", res_sum, 510);
        check("R9 sumsq", res_sumsq, 130050);
        check("R9 jumps", res_jumps, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero();
        t_boundary();
        t_gaps();
        t_outside();
        t_max();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule